// File: doc/BRIEF.md
# Pulse-Coded Isolation Link Codec

This block carries a single logic level across a link that can pass only short pulses. A transmit half, clocked by its own encoder clock, synchronizes the incoming level and turns every change into a one-cycle pulse. A rising change is sent on a "set" wire and a falling change on a "clear" wire. When the level stays put, the transmit half restates it with periodic refresh pulses on the matching wire, so the far side stays correct at DC and can tell a live sender from a dead one.

The receive half, clocked by its own decoder clock, carries each wire into its domain without losing a pulse. It keeps the level in a set/clear latch and watches the pulse stream with a watchdog. If the stream goes quiet for too long, it raises a fault flag and drives the output to a safe default (logic high). The first valid pulse after that clears the fault and restores the true level. The link wires are timed by the encoder clock. The system can route them through whatever barrier model it needs between `tx_set`/`tx_clr` and `rx_set`/`rx_clr`.

Top module: `pulse_link_codec`

## Requirements
- R1: A change of `level_in` produces exactly one encoder-cycle pulse: `tx_set` for a rise and `tx_clr` for a fall. The pulse appears on the third encoder clock edge after the first edge that samples the new level. `tx_set` and `tx_clr` are never high together.
- R2: After a transition pulse, if no further change occurs, a refresh pulse is sent exactly `IDLE_CYC` encoder cycles later. It goes on `tx_set` when the held level is 1 and on `tx_clr` when it is 0.
- R3: After a refresh pulse, further refresh pulses follow every `REFRESH_CYC` encoder cycles while the level is unchanged. With the link connected, this keeps the watchdog from firing.
- R4: A transition restarts the refresh timer. A transition that falls on the same cycle as a due refresh sends only the transition pulse, and the next refresh is again `IDLE_CYC` cycles later.
- R5: A valid pulse on `rx_set` drives `level_out` to 1 and a valid pulse on `rx_clr` drives it to 0. Rising and falling changes pass through the same chain of register stages (2 synchronizer, 1 pulse, 1 toggle, 2 decoder synchronizer, 1 latch), so both see equal latency, and no pulse is lost even when `level_in` toggles every encoder cycle.
- R6: Pulses on `rx_set` and `rx_clr` in the same encoder cycle have no effect: `level_out` and `link_fault` keep their values, and the watchdog is not restarted.
- R7: If no valid pulse is received for `WDOG_CYC` decoder cycles, `link_fault` goes to 1 and `level_out` to the default level 1. It stays there until a valid pulse arrives.
- R8: The first valid pulse received while `link_fault` is 1 clears `link_fault` and loads the latch in the same decoder cycle. After the sender resumes, this happens within one refresh interval plus the pipeline latency.
- R9: After reset, `level_out` is 1, `link_fault` is 1, and `tx_set`/`tx_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_clk | input | 1 | Encoder clock; also times the link wires |
| enc_rst_n | input | 1 | Encoder asynchronous reset, active low |
| level_in | input | 1 | Level to carry, asynchronous to enc_clk |
| tx_set | output | 1 | One-cycle pulse: level is (or became) high |
| tx_clr | output | 1 | One-cycle pulse: level is (or became) low |
| dec_clk | input | 1 | Decoder clock |
| dec_rst_n | input | 1 | Decoder asynchronous reset, active low |
| rx_set | input | 1 | Received set wire, encoder-clock timed |
| rx_clr | input | 1 | Received clear wire, encoder-clock timed |
| level_out | output | 1 | Reconstructed level, default 1 on fault |
| link_fault | output | 1 | High when the sender is considered silent |

## Verification
The bench builds the block with `IDLE_CYC=12`, `REFRESH_CYC=9` and `WDOG_CYC=40`, with both clocks at the same rate and a fixed 3 ns phase offset, so every latency is a known whole number of cycles. These short intervals let a sweep of every hold length from 1 to `IDLE_CYC+2*REFRESH_CYC+2` cycles run in a few hundred cycles. That sweep covers back-to-back toggles, transitions landing exactly on a due refresh, and chains of two refreshes, and each cycle is compared against an arithmetic pulse schedule. The bench also takes over the receive wires to force simultaneous pulses and silence. With a 40-cycle watchdog, the exact timeout cycle, the ignored pulse pair and the recovery after reconnection all fit in a short run.

// File: rtl/pulse_link_pkg.sv
package pulse_link_pkg;

    // Wire indices of the pulse link; the decoder relies on this order.
    localparam int NUM_WIRES = 2;
    localparam int W_SET     = 0;
    localparam int W_CLR     = 1;

    // What the encoder emits in a given cycle.
    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_EDGE    = 2'd1,
        EV_REFRESH = 2'd2
    } enc_event_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/plc_encoder.sv
module plc_encoder
    import pulse_link_pkg::*;
#(
    parameter int IDLE_CYC    = 100,
    parameter int REFRESH_CYC = 85,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 level_in,
    output logic [NUM_WIRES-1:0] pulse_out
);

    localparam int MAX_CYC = max2(IDLE_CYC, REFRESH_CYC);
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC - 1);
    localparam logic [CW-1:0] REFR_LAST = CW'(REFRESH_CYC - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;       // input synchronizer chain
        logic                   held;       // last level announced
        logic [CW-1:0]          cnt;        // cycles since last pulse
        logic                   after_edge; // last pulse was a transition
        logic [NUM_WIRES-1:0]   pulse;      // registered link wires
    } enc_state_t;

    localparam enc_state_t ENC_RST = '{
        sync:       '0,
        held:       1'b0,
        cnt:        '0,
        after_edge: 1'b1,
        pulse:      '0
    };

    enc_state_t st_q, st_d;
    enc_event_e ev;
    logic       seen;
    logic [CW-1:0] due;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], level_in};
        seen      = st_q.sync[SYNC_STAGES-1];
        due       = st_q.after_edge ? IDLE_LAST : REFR_LAST;

        // A transition always outranks a refresh falling due in the same cycle.
        if (seen != st_q.held) begin
            ev = EV_EDGE;
        end else if (st_q.cnt == due) begin
            ev = EV_REFRESH;
        end else begin
            ev = EV_NONE;
        end

        st_d.pulse = '0;
        unique case (ev)
            EV_EDGE: begin
                st_d.held         = seen;
                st_d.pulse[W_SET] = seen;
                st_d.pulse[W_CLR] = ~seen;
                st_d.cnt          = '0;
                st_d.after_edge   = 1'b1;
            end
            EV_REFRESH: begin
                st_d.pulse[W_SET] = st_q.held;
                st_d.pulse[W_CLR] = ~st_q.held;
                st_d.cnt          = '0;
                st_d.after_edge   = 1'b0;
            end
            default: begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ENC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_out = st_q.pulse;

endmodule

// File: rtl/plc_toggle_xfer.sv
module plc_toggle_xfer #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);

    // Source side: each pulse flips a level, so no pulse can be missed.
    logic tog_q, tog_d;

    always_comb begin
        tog_d = tog_q ^ src_pulse;
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    // Destination side: synchronizer plus one history flop for change detection.
    logic [SYNC_STAGES:0] ring_q, ring_d;

    always_comb begin
        ring_d = {ring_q[SYNC_STAGES-1:0], tog_q};
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign dst_pulse = ring_q[SYNC_STAGES] ^ ring_q[SYNC_STAGES-1];

endmodule

// File: rtl/plc_decoder.sv
module plc_decoder
    import pulse_link_pkg::*;
#(
    parameter int   WDOG_CYC      = 500,
    parameter logic DEFAULT_LEVEL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WIRES-1:0] pulse_in,
    output logic                 level_out,
    output logic                 fault
);

    localparam int CW = $clog2(WDOG_CYC + 1);
    localparam logic [CW-1:0] WD_LAST = CW'(WDOG_CYC - 1);

    typedef struct packed {
        logic          latch; // set/clear latch, drives the output
        logic          fault; // sender considered silent
        logic [CW-1:0] quiet; // cycles without a valid pulse
    } dec_state_t;

    localparam dec_state_t DEC_RST = '{
        latch: DEFAULT_LEVEL,
        fault: 1'b1,
        quiet: '0
    };

    dec_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case ({pulse_in[W_CLR], pulse_in[W_SET]})
            2'b01: begin
                st_d.latch = 1'b1;
                st_d.fault = 1'b0;
                st_d.quiet = '0;
            end
            2'b10: begin
                st_d.latch = 1'b0;
                st_d.fault = 1'b0;
                st_d.quiet = '0;
            end
            default: begin
                // No pulse, or a contradictory pair: watchdog keeps running.
                if (!st_q.fault) begin
                    if (st_q.quiet == WD_LAST) begin
                        st_d.fault = 1'b1;
                        st_d.latch = DEFAULT_LEVEL;
                        st_d.quiet = '0;
                    end else begin
                        st_d.quiet = st_q.quiet + CW'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DEC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_out = st_q.latch;
    assign fault     = st_q.fault;

endmodule

// File: rtl/pulse_link_codec.sv
module pulse_link_codec
    import pulse_link_pkg::*;
#(
    parameter int   IDLE_CYC      = 100,
    parameter int   REFRESH_CYC   = 85,
    parameter int   WDOG_CYC      = 500,
    parameter int   SYNC_STAGES   = 2,
    parameter logic DEFAULT_LEVEL = 1'b1
) (
    input  logic enc_clk,
    input  logic enc_rst_n,
    input  logic level_in,
    output logic tx_set,
    output logic tx_clr,
    input  logic dec_clk,
    input  logic dec_rst_n,
    input  logic rx_set,
    input  logic rx_clr,
    output logic level_out,
    output logic link_fault
);

    logic [NUM_WIRES-1:0] tx_pulse;
    logic [NUM_WIRES-1:0] rx_wire;
    logic [NUM_WIRES-1:0] rx_pulse;

    plc_encoder #(
        .IDLE_CYC    (IDLE_CYC),
        .REFRESH_CYC (REFRESH_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_enc (
        .clk       (enc_clk),
        .rst_n     (enc_rst_n),
        .level_in  (level_in),
        .pulse_out (tx_pulse)
    );

    assign tx_set = tx_pulse[W_SET];
    assign tx_clr = tx_pulse[W_CLR];

    assign rx_wire[W_SET] = rx_set;
    assign rx_wire[W_CLR] = rx_clr;

    // One toggle crossing per link wire; the wires are timed by enc_clk.
    for (genvar g = 0; g < NUM_WIRES; g++) begin : g_xfer
        plc_toggle_xfer #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_xfer (
            .src_clk   (enc_clk),
            .src_rst_n (enc_rst_n),
            .src_pulse (rx_wire[g]),
            .dst_clk   (dec_clk),
            .dst_rst_n (dec_rst_n),
            .dst_pulse (rx_pulse[g])
        );
    end

    plc_decoder #(
        .WDOG_CYC      (WDOG_CYC),
        .DEFAULT_LEVEL (DEFAULT_LEVEL)
    ) u_dec (
        .clk       (dec_clk),
        .rst_n     (dec_rst_n),
        .pulse_in  (rx_pulse),
        .level_out (level_out),
        .fault     (link_fault)
    );

endmodule

// File: rtl/pulse_link_chk.sv
module pulse_link_chk
    import pulse_link_pkg::*;
#(
    parameter int   IDLE_CYC      = 100,
    parameter int   REFRESH_CYC   = 85,
    parameter int   WDOG_CYC      = 500,
    parameter logic DEFAULT_LEVEL = 1'b1
) (
    input logic                 enc_clk,
    input logic                 enc_rst_n,
    input logic                 tx_set,
    input logic                 tx_clr,
    input logic                 dec_clk,
    input logic                 dec_rst_n,
    input logic                 level_out,
    input logic                 link_fault,
    input logic [NUM_WIRES-1:0] rx_pulse
);

    localparam int MAXGAP = max2(IDLE_CYC, REFRESH_CYC);

    // Encoder-side count of cycles without a pulse on either wire.
    int gap_q;
    always_ff @(posedge enc_clk or negedge enc_rst_n) begin
        if (!enc_rst_n) begin
            gap_q <= 0;
        end else if (tx_set || tx_clr) begin
            gap_q <= 0;
        end else if (gap_q <= MAXGAP) begin
            gap_q <= gap_q + 1;
        end
    end

    // Decoder-side count of cycles without a valid (single-wire) pulse.
    int silent_q;
    always_ff @(posedge dec_clk or negedge dec_rst_n) begin
        if (!dec_rst_n) begin
            silent_q <= 0;
        end else if (rx_pulse[W_SET] ^ rx_pulse[W_CLR]) begin
            silent_q <= 0;
        end else if (silent_q < WDOG_CYC) begin
            silent_q <= silent_q + 1;
        end
    end

    a_r1_wires_exclusive: assert property (@(posedge enc_clk) disable iff (!enc_rst_n)
        !(tx_set && tx_clr));

    a_r1_set_single_cycle: assert property (@(posedge enc_clk) disable iff (!enc_rst_n)
        tx_set |=> !tx_set);

    a_r1_clr_single_cycle: assert property (@(posedge enc_clk) disable iff (!enc_rst_n)
        tx_clr |=> !tx_clr);

    a_r2_refresh_bound: assert property (@(posedge enc_clk) disable iff (!enc_rst_n)
        gap_q <= MAXGAP);

    a_r6_pair_ignored: assert property (@(posedge dec_clk) disable iff (!dec_rst_n)
        (rx_pulse[W_SET] && rx_pulse[W_CLR]) |=> ($stable(level_out) || link_fault));

    a_r7_timeout_raises_fault: assert property (@(posedge dec_clk) disable iff (!dec_rst_n)
        (silent_q >= WDOG_CYC) |-> link_fault);

    a_r7_fault_forces_default: assert property (@(posedge dec_clk) disable iff (!dec_rst_n)
        link_fault |-> (level_out == DEFAULT_LEVEL));

    a_r8_first_pulse_recovers: assert property (@(posedge dec_clk) disable iff (!dec_rst_n)
        (link_fault && (rx_pulse[W_SET] ^ rx_pulse[W_CLR]))
            |=> (!link_fault && (level_out == $past(rx_pulse[W_SET]))));

endmodule

bind pulse_link_codec pulse_link_chk #(
    .IDLE_CYC      (IDLE_CYC),
    .REFRESH_CYC   (REFRESH_CYC),
    .WDOG_CYC      (WDOG_CYC),
    .DEFAULT_LEVEL (DEFAULT_LEVEL)
) chk_i (
    .enc_clk    (enc_clk),
    .enc_rst_n  (enc_rst_n),
    .tx_set     (tx_set),
    .tx_clr     (tx_clr),
    .dec_clk    (dec_clk),
    .dec_rst_n  (dec_rst_n),
    .level_out  (level_out),
    .link_fault (link_fault),
    .rx_pulse   (rx_pulse)
);

// File: tb/pulse_link_codec_tb.sv
module pulse_link_codec_tb_top;

    localparam int IDLE   = 12;
    localparam int REFR   = 9;
    localparam int WDOG   = 40;
    localparam int MAXGAP = (IDLE > REFR) ? IDLE : REFR;
    localparam int HMAX   = IDLE + 2 * REFR + 2;

    logic enc_clk, enc_rst_n, level_in, tx_set, tx_clr;
    logic dec_clk, dec_rst_n, rx_set, rx_clr, level_out, link_fault;
    logic inj_mode, inj_set, inj_clr;

    int n_chk = 0;
    int n_bad = 0;

    // Link: straight through, or taken over by the bench.
    assign rx_set = inj_mode ? inj_set : tx_set;
    assign rx_clr = inj_mode ? inj_clr : tx_clr;

    pulse_link_codec #(
        .IDLE_CYC      (IDLE),
        .REFRESH_CYC   (REFR),
        .WDOG_CYC      (WDOG),
        .SYNC_STAGES   (2),
        .DEFAULT_LEVEL (1'b1)
    ) dut_i (
        .enc_clk    (enc_clk),
        .enc_rst_n  (enc_rst_n),
        .level_in   (level_in),
        .tx_set     (tx_set),
        .tx_clr     (tx_clr),
        .dec_clk    (dec_clk),
        .dec_rst_n  (dec_rst_n),
        .rx_set     (rx_set),
        .rx_clr     (rx_clr),
        .level_out  (level_out),
        .link_fault (link_fault)
    );

    // 100 MHz clocks; the decoder clock trails by 3 ns.
    initial begin
        enc_clk = 1'b0;
        forever #5 enc_clk = ~enc_clk;
    end

    initial begin
        dec_clk = 1'b0;
        #3;
        forever #5 dec_clk = ~dec_clk;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Schedule monitor: samples 4 ns after each encoder edge. An input change
    // first seen in sample m is expected on the wires in sample m+3 and on
    // level_out in sample m+6.
    logic hist [0:7];
    bit   mon_en = 1'b0;
    bit   armed  = 1'b0;
    int   gap    = 0;
    bit   aft    = 1'b1;

    initial begin
        for (int i = 0; i < 8; i++) hist[i] = 1'b0;
        forever begin
            @(posedge enc_clk);
            #4;
            for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = level_in;
            if (mon_en) begin
                bit exp_s, exp_c;
                exp_s = 1'b0;
                exp_c = 1'b0;
                if (hist[3] != hist[4]) begin
                    armed = 1'b1;
                    gap   = 0;
                    aft   = 1'b1;
                    exp_s = hist[3];
                    exp_c = !hist[3];
                end else if (armed) begin
                    gap++;
                    if (gap == (aft ? IDLE : REFR)) begin
                        exp_s = hist[3];
                        exp_c = !hist[3];
                        gap   = 0;
                        aft   = 1'b0;
                    end
                end
                if (armed) begin
                    chk(tx_set == exp_s && tx_clr == exp_c,
                        "R1 R2 R3 R4 pulse schedule {set,clr}",
                        {tx_set, tx_clr}, {exp_s, exp_c});
                    chk(level_out == hist[6] && !link_fault,
                        "R5 level_out follows level_in {fault,level}",
                        {link_fault, level_out}, {1'b0, hist[6]});
                end
            end
        end
    end

    // Watchdog for a hung run.
    initial begin
        repeat (200000) @(posedge enc_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int rec_n;
        int bad_cnt;
        level_in  = 1'b0;
        inj_mode  = 1'b0;
        inj_set   = 1'b0;
        inj_clr   = 1'b0;
        enc_rst_n = 1'b0;
        dec_rst_n = 1'b0;
        repeat (4) @(posedge enc_clk);
        #1;
        enc_rst_n = 1'b1;
        dec_rst_n = 1'b1;

        // Reset state, then the first refresh clears the fault.
        for (int n = 1; n <= IDLE + 4; n++) begin
            @(posedge enc_clk);
            #4;
            if (n == 3) begin
                chk(level_out == 1'b1, "R9 reset level_out", level_out, 1);
                chk(link_fault == 1'b1, "R9 reset link_fault", link_fault, 1);
                chk(!tx_set && !tx_clr, "R9 reset link wires quiet", {tx_set, tx_clr}, 0);
            end
            if (n == IDLE + 2)
                chk(link_fault == 1'b1, "R8 fault held before first pulse", link_fault, 1);
            if (n == IDLE + 3)
                chk(!link_fault && level_out == 1'b0, "R8 first refresh clears fault {fault,level}",
                    {link_fault, level_out}, 0);
        end

        // Sweep every hold length across both refresh thresholds.
        @(posedge enc_clk);
        #1;
        mon_en = 1'b1;
        for (int h = 1; h <= HMAX; h++) begin
            level_in = !level_in;
            repeat (h) @(posedge enc_clk);
            #1;
        end
        repeat (IDLE + 3 * REFR + 10) @(posedge enc_clk);
        #1;
        mon_en = 1'b0;
        armed  = 1'b0;

        // Settle high, then take over the link.
        level_in = 1'b1;
        repeat (20) @(posedge enc_clk);
        #4;
        chk(level_out == 1'b1 && !link_fault, "R5 settled high {fault,level}",
            {link_fault, level_out}, 1);
        inj_mode = 1'b1;
        repeat (8) @(posedge enc_clk);
        #1;
        inj_clr = 1'b1;
        @(posedge enc_clk);
        #1;
        inj_clr = 1'b0;
        for (int n = 1; n <= WDOG + 3; n++) begin
            @(posedge enc_clk);
            #4;
            if (n == 2)
                chk(level_out == 1'b0 && !link_fault, "R5 injected clear {fault,level}",
                    {link_fault, level_out}, 0);
            if (n == 5) begin
                inj_set = 1'b1;
                inj_clr = 1'b1;
            end
            if (n == 6) begin
                inj_set = 1'b0;
                inj_clr = 1'b0;
            end
            if (n == 10)
                chk(level_out == 1'b0 && !link_fault, "R6 pair ignored {fault,level}",
                    {link_fault, level_out}, 0);
            if (n == WDOG + 1)
                chk(level_out == 1'b0 && !link_fault, "R6 R7 no restart and no early timeout {fault,level}",
                    {link_fault, level_out}, 0);
            if (n == WDOG + 2)
                chk(level_out == 1'b1 && link_fault, "R7 timeout forces default {fault,level}",
                    {link_fault, level_out}, 3);
        end
        repeat (5) @(posedge enc_clk);
        #4;
        chk(level_out == 1'b1 && link_fault, "R7 fault held while silent {fault,level}",
            {link_fault, level_out}, 3);

        // Sender changes level while cut off, then the link is restored.
        level_in = 1'b0;
        repeat (10) @(posedge enc_clk);
        #1;
        inj_mode = 1'b0;
        rec_n = -1;
        for (int n = 1; n <= MAXGAP + 8; n++) begin
            @(posedge enc_clk);
            #4;
            if (rec_n < 0 && !link_fault) begin
                rec_n = n;
                chk(level_out == 1'b0, "R8 recovery loads true level", level_out, 0);
            end
        end
        chk(rec_n > 0 && rec_n <= MAXGAP + 5, "R8 recovery cycles", rec_n, MAXGAP + 5);

        // Refreshes keep a connected, idle link alive.
        bad_cnt = 0;
        for (int n = 0; n < 3 * WDOG; n++) begin
            @(posedge enc_clk);
            #4;
            if (link_fault || level_out != 1'b0) bad_cnt++;
        end
        chk(bad_cnt == 0, "R3 idle link stays healthy (bad cycles)", bad_cnt, 0);

        summary();
        $finish;
    end

endmodule